// File: doc/BRIEF.md
# Multi-Channel Pulse-Capture Bus Interface

This block sits between a host and eight parallel devices. Each device announces a new 8-bit word with a brief data-available strobe. On the rising edge of that strobe the block latches the word into a per-channel holding register and sets a sticky ready flag. The flag stays set until the host clears it, so a host that polls late still sees every sample.

The host reads the eight ready flags on a dedicated flag port. It reads data through one shared 8-bit bus and picks the source channel with per-channel output-enable lines. To request a sample, the host pulses a channel's trigger line high, then low, then high. The falling step of that pulse clears the channel's flag. The host can also clear a flag through a separate reset line for each channel.

The shared bus is a registered one-hot selector. With no enable asserted it reads zero and reports idle. With several enables asserted it outputs the lowest-numbered enabled channel and reports contention. All inputs are sampled on one clock. Strobes pass through a two-stage synchronizer and must last at least two clock cycles.

Top module: `pulse_capture_hub`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `ready_o` is 0, `bus_o` is 0, `bus_idle_o` is 1, `contention_o` is 0 and `trig_o` is all ones.
- R2: A strobe on channel i that rises before clock edge k sets `ready_o[i]` at edge k+2 and not earlier. At the same edge the register of channel i captures `data_i[8*i+7:8*i]`.
- R3: The flag and the captured word persist after the strobe falls. Later changes on that channel's data lines do not alter the captured word.
- R4: `flag_clr_i[i]` high at an edge clears `ready_o[i]` at that edge unless a capture happens on channel i in the same cycle.
- R5: `trig_o` is `host_trig_i` delayed by one cycle. A high-to-low step of `host_trig_i[i]` clears `ready_o[i]` at the next edge.
- R6: If a capture and a clear on the same channel fall in the same cycle, the flag ends up set.
- R7: With only `oe_i[i]` high, `bus_o` shows channel i's register one cycle later, and `bus_idle_o` and `contention_o` are 0.
- R8: With `oe_i` all zero, `bus_o` is 0 and `bus_idle_o` is 1 one cycle later.
- R9: With two or more bits of `oe_i` high, `bus_o` shows the lowest-numbered enabled channel and `contention_o` is 1 one cycle later.
- R10: A capture or a clear on one channel leaves the flags and words of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 8 | Per-device data-available strobes |
| data_i | input | 64 | Device words; channel i occupies bits 8i+7:8i |
| host_trig_i | input | 8 | Host trigger request lines |
| flag_clr_i | input | 8 | Host flag clear lines |
| oe_i | input | 8 | Host output-enable lines, one per channel |
| trig_o | output | 8 | Registered trigger lines to devices, idle high |
| ready_o | output | 8 | Sticky data-ready flags |
| bus_o | output | 8 | Shared read bus |
| bus_idle_o | output | 1 | No channel enabled |
| contention_o | output | 1 | More than one channel enabled |

## Verification
A wrong flag bit appears on `ready_o` at the edge where it goes wrong. The bench checks that port at the exact cycle a capture lands, so an early, late or lost set is caught within one clock. A corrupted holding register stays hidden until the host enables that channel, and then shows on `bus_o` one cycle later. For that reason the bench sweeps all 256 enable patterns after every channel holds a distinct word. That sweep also exposes a wrong priority order or a wrong idle or contention decode.

// File: rtl/pulse_capture_hub.sv
module pulse_capture_hub #(
  parameter int NCH = 8,
  parameter int W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   strobe_i,
  input  logic [NCH*W-1:0] data_i,
  input  logic [NCH-1:0]   host_trig_i,
  input  logic [NCH-1:0]   flag_clr_i,
  input  logic [NCH-1:0]   oe_i,
  output logic [NCH-1:0]   trig_o,
  output logic [NCH-1:0]   ready_o,
  output logic [W-1:0]     bus_o,
  output logic             bus_idle_o,
  output logic             contention_o
);

  logic [NCH-1:0] sync_a, sync_b, sync_c;
  logic [W-1:0]   word_q [NCH];
  logic [W-1:0]   pick;

  wire [NCH-1:0] cap   = sync_b & ~sync_c;
  wire [NCH-1:0] wipe  = flag_clr_i | (trig_o & ~host_trig_i);
  wire           multi = (oe_i & (oe_i - NCH'(1))) != '0;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (oe_i[i]) pick = word_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a       <= '0;
      sync_b       <= '0;
      sync_c       <= '0;
      trig_o       <= '1;
      ready_o      <= '0;
      bus_o        <= '0;
      bus_idle_o   <= 1'b1;
      contention_o <= 1'b0;
      for (int i = 0; i < NCH; i++) word_q[i] <= '0;
    end else begin
      sync_a       <= strobe_i;
      sync_b       <= sync_a;
      sync_c       <= sync_b;
      trig_o       <= host_trig_i;
      ready_o      <= (ready_o & ~wipe) | cap;
      bus_o        <= pick;
      bus_idle_o   <= oe_i == '0;
      contention_o <= multi;
      for (int i = 0; i < NCH; i++)
        if (cap[i]) word_q[i] <= data_i[i*W +: W];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    localparam logic [NCH-1:0] BELOW = (NCH'(1) << g) - NCH'(1);

    // R2 R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      cap[g] |=> ready_o[g]);

    // R4
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_clr_i[g] && !cap[g]) |=> !ready_o[g]);

    // R3 R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!cap[g] && !wipe[g]) |=> $stable(ready_o[g]));

    // R7 R9
    bus_pick_chk: assert property (@(posedge clk) disable iff (rst)
      (oe_i[g] && (oe_i & BELOW) == '0) |=> bus_o == $past(word_q[g]));
  end

  // R8
  bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_i == '0) |=> (bus_idle_o && bus_o == '0 && !contention_o));

  // R9
  contention_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(oe_i) > 1) |=> (contention_o && !bus_idle_o));

endmodule

// File: tb/tb_pulse_capture_hub.sv
`timescale 1ns/1ps
module tb_pulse_capture_hub;
  logic        clk = 0;
  logic        rst;
  logic [7:0]  strobe_i, host_trig_i, flag_clr_i, oe_i;
  logic [63:0] data_i;
  logic [7:0]  trig_o, ready_o, bus_o;
  logic        bus_idle_o, contention_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_word [8];
  logic [7:0] exp_ready;

  always #5 clk = ~clk;

  pulse_capture_hub dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int ch);
    return 8'(8'h1B + ch * 8'h35);
  endfunction

  task automatic capture(input int ch, input logic [7:0] v);
    data_i[ch*8 +: 8] = v;
    strobe_i[ch] = 1'b1;
    step(2);
    strobe_i[ch] = 1'b0;
    step(2);
    data_i[ch*8 +: 8] = ~v;
    exp_word[ch] = v;
    exp_ready[ch] = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1; strobe_i = 0; data_i = 0; host_trig_i = '1; flag_clr_i = 0; oe_i = 0;
    exp_ready = 0;
    for (int i = 0; i < 8; i++) exp_word[i] = 0;
    step(3);
    // R1
    chk(ready_o == 0 && bus_o == 0 && bus_idle_o && !contention_o && trig_o == 8'hFF,
        "R1 reset", {ready_o, bus_o}, 16'h0);
    rst = 0;
    step(1);
    chk(ready_o == 0 && bus_idle_o && trig_o == 8'hFF, "R1 after release", ready_o, 0);

    // R2 exact latency on channel 3
    data_i[24 +: 8] = 8'hA5;
    strobe_i[3] = 1'b1;
    step(2);
    chk(ready_o[3] == 1'b0, "R2 not early", ready_o, 0);
    step(1);
    chk(ready_o == 8'h08, "R2 set at k+2", ready_o, 8'h08);
    strobe_i[3] = 1'b0;
    data_i[24 +: 8] = 8'h3C;
    step(4);
    // R3
    chk(ready_o == 8'h08, "R3 flag persists", ready_o, 8'h08);
    oe_i = 8'h08; step(1);
    chk(bus_o == 8'hA5, "R3 word held", bus_o, 8'hA5);
    oe_i = 0;
    exp_ready[3] = 1; exp_word[3] = 8'hA5;

    // R10 capture every channel, flags accumulate one by one
    for (int c = 0; c < 8; c++) begin
      capture(c, pat(c));
      chk(ready_o == exp_ready, $sformatf("R10 ch%0d flags", c), ready_o, exp_ready);
    end

    // R7 R8 R9 sweep all enable patterns
    for (int m = 0; m < 256; m++) begin
      logic [7:0] eb; int lo; int cnt;
      oe_i = 8'(m);
      step(1);
      lo = -1; cnt = 0;
      for (int b = 7; b >= 0; b--) if (m[b]) begin lo = b; cnt++; end
      eb = (lo < 0) ? 8'h00 : exp_word[lo];
      chk(bus_o == eb, $sformatf("R7 R9 bus oe=%0h", m), bus_o, eb);
      chk(bus_idle_o == (cnt == 0), "R8 idle", bus_idle_o, cnt == 0);
      chk(contention_o == (cnt > 1), "R9 contention", contention_o, cnt > 1);
    end
    oe_i = 0;

    // R4 host clear on channel 5
    flag_clr_i[5] = 1; step(1); flag_clr_i[5] = 0;
    exp_ready[5] = 0;
    chk(ready_o == exp_ready, "R4 clear ch5 R10 others", ready_o, exp_ready);
    step(2);
    chk(ready_o == exp_ready, "R4 stays clear", ready_o, exp_ready);

    // R5 trigger high-low-high on channel 2
    host_trig_i[2] = 0; step(1);
    exp_ready[2] = 0;
    chk(trig_o == 8'hFB, "R5 trig follows", trig_o, 8'hFB);
    chk(ready_o == exp_ready, "R5 falling clears", ready_o, exp_ready);
    host_trig_i[2] = 1; step(1);
    chk(trig_o == 8'hFF, "R5 trig idle high", trig_o, 8'hFF);
    chk(ready_o == exp_ready, "R5 rise no effect", ready_o, exp_ready);

    // R6 set wins over simultaneous clear on channel 5
    data_i[40 +: 8] = 8'h77;
    strobe_i[5] = 1;
    step(2);
    flag_clr_i[5] = 1;
    step(1);
    flag_clr_i[5] = 0; strobe_i[5] = 0;
    exp_ready[5] = 1; exp_word[5] = 8'h77;
    chk(ready_o == exp_ready, "R6 set priority", ready_o, exp_ready);
    oe_i = 8'h20; step(1);
    chk(bus_o == 8'h77, "R6 word captured", bus_o, 8'h77);
    oe_i = 8'h04; step(1);
    chk(bus_o == pat(2), "R10 ch2 word kept", bus_o, pat(2));
    oe_i = 0; step(1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule